// File: doc/BRIEF.md
# UART Receive Buffer with Level and Timeout Interrupts

This block is the receive-side character store of a memory-mapped UART. Characters from the serial receiver (or from the loopback path) arrive through a single-cycle push strobe with a data byte. The register block takes them out through a pop strobe issued when software reads the data register. The block reports its occupancy, registered full and empty flags and a sticky overrun flag. It also keeps the two raw receive interrupt bits that the register block masks and combines: a level interrupt and a timeout interrupt.

The storage depth is chosen at run time. When the enable input is low the buffer acts as a single holding register. When it is high the buffer is a FIFO of `DEPTH` entries (16 by default). Any change of the enable input discards the stored characters and applies the new depth. The level interrupt uses a threshold picked by a 3-bit select. It is raised only when a push carries the occupancy up across that threshold. It drops when a pop leaves the occupancy below the threshold.

Top module: `uart_rx_buffer`

## Requirements
- R1: After a synchronous reset, occupancy is 0, `empty` is 1, `full` is 0, `rd_data` is 0x00, the overrun and both interrupt outputs are 0, and the buffer is in one-entry mode.
- R2: With `fifo_en` high and settled, the buffer accepts up to `DEPTH` (16) characters. With it low, it accepts one character. `full` is 1 exactly when the occupancy equals the current depth, and `empty` is 1 exactly when the occupancy is 0.
- R3: In a cycle where `fifo_en` differs from the mode currently applied, the buffer is emptied and the new depth takes effect. Push and pop in that cycle are ignored. The overrun and interrupt outputs are left unchanged, apart from explicit clears.
- R4: In FIFO mode, threshold select codes 0, 1, 2, 3 and 4 give thresholds of 2, 4, 8, 12 and 14 characters, and codes 5, 6 and 7 give 16. In one-entry mode the threshold is 1 for every code.
- R5: `lvl_irq` is set by an accepted push that moves the occupancy from below the threshold to at or above it. It is cleared by an accepted pop that leaves the occupancy below the threshold. Changing the select alone does not set it.
- R6: `tmo_irq` is set by every accepted push and is cleared by an accepted pop that leaves the buffer empty.
- R7: A push into a full buffer with no pop accepted in the same cycle is discarded. Stored data and occupancy are kept, and `overrun` is set. `overrun` stays set until `overrun_clr`. A discard in the same cycle as the clear leaves it set.
- R8: A push and a pop in the same cycle on a non-empty buffer are both accepted, and the occupancy is unchanged. A pop on an empty buffer is ignored.
- R9: Characters leave in arrival order. `rd_data` shows the popped character from the cycle after the pop and holds it until the next accepted pop.
- R10: `lvl_clr` and `tmo_clr` clear their interrupt one cycle later. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Depth mode: 1 = FIFO of DEPTH entries, 0 = one-entry register |
| thr_sel | input | 3 | Receive threshold select code |
| push | input | 1 | Character-arrival strobe |
| push_data | input | 8 | Arriving character |
| pop | input | 1 | Data-register read strobe |
| overrun_clr | input | 1 | Clears the overrun flag |
| lvl_clr | input | 1 | Clears the level interrupt |
| tmo_clr | input | 1 | Clears the timeout interrupt |
| rd_data | output | 8 | Last popped character |
| count | output | 5 | Current occupancy |
| full | output | 1 | Occupancy equals current depth |
| empty | output | 1 | Occupancy is zero |
| overrun | output | 1 | Sticky discarded-character flag |
| lvl_irq | output | 1 | Raw receive-level interrupt |
| tmo_irq | output | 1 | Raw receive-timeout interrupt |

## Verification
On every cycle the assertions check these properties: the occupancy never exceeds the current depth, and full and empty are never high together. A mode change always leaves the buffer empty. A discarded push keeps the occupancy. A push with a pop keeps it as well. Every accepted push raises the timeout interrupt, and a pop that falls below the threshold drops the level interrupt. The threshold table for each select code, first-in first-out data order and the hold of `rd_data` can only be shown by the bench's scenarios. The same holds for flag retention across a flush and for set-over-clear priority. The bench shows these by comparing with its queue model on every cycle and by the sweep over all select codes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Receive threshold for a select code; one-entry mode always uses 1.
  function automatic int unsigned rx_thresh(input logic [2:0] sel,
                                            input logic       fifo_mode,
                                            input int unsigned depth);
    if (!fifo_mode) return 1;
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth;
    endcase
  endfunction

  // Pointer advance: wraps at the active depth (always 0 in one-entry mode).
  function automatic int unsigned ptr_next(input int unsigned ptr,
                                           input logic       fifo_mode,
                                           input int unsigned depth);
    if (!fifo_mode) return 0;
    if (ptr == depth - 1) return 0;
    return ptr + 1;
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          push,
  input  logic          pop,
  input  logic          overrun_clr,
  output logic          mode_q,
  output logic          flush,
  output logic          push_acc,
  output logic          pop_acc,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nx,
  output logic          full_q,
  output logic          empty_q,
  output logic          ovr_q
);

  localparam logic [CW-1:0] CAP_BIG = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_ONE = CW'(1);

  logic [CW-1:0] cap_now;
  logic [CW-1:0] cap_nx;
  logic          drop;

  assign cap_now = mode_q  ? CAP_BIG : CAP_ONE;
  assign cap_nx  = fifo_en ? CAP_BIG : CAP_ONE;
  assign flush   = (fifo_en != mode_q);

  always_comb begin
    pop_acc  = !flush && pop && (cnt_q != '0);
    push_acc = !flush && push && ((cnt_q != cap_now) || pop_acc);
    drop     = !flush && push && !push_acc;
    if (flush) cnt_nx = '0;
    else       cnt_nx = cnt_q + CW'(push_acc) - CW'(pop_acc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      mode_q  <= fifo_en;
      cnt_q   <= cnt_nx;
      full_q  <= (cnt_nx == cap_nx);
      empty_q <= (cnt_nx == '0);
      ovr_q   <= drop | (ovr_q & ~overrun_clr);
    end
  end

  // R2: occupancy bounded by active depth
  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cap_now);
  // R2: full and empty are exclusive
  p_flags_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q));
  // R3: a mode change empties the buffer
  p_flush_empties_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_en != mode_q) |=> (cnt_q == '0) && empty_q);
  // R7: a discarded push keeps occupancy and raises overrun
  p_drop_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full_q && (fifo_en == mode_q)) |=> $stable(cnt_q) && ovr_q);
  // R8: simultaneous push and pop keep occupancy
  p_both_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty_q && (fifo_en == mode_q)) |=> $stable(cnt_q));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_q,
  input  logic         flush,
  input  logic         push_acc,
  input  logic         pop_acc,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  import rxq_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  // Storage array: no reset, write port and registered read port.
  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (pop_acc) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_acc) wr_ptr <= AW'(ptr_next(int'(wr_ptr), mode_q, DEPTH));
      if (pop_acc)  rd_ptr <= AW'(ptr_next(int'(rd_ptr), mode_q, DEPTH));
    end
  end

  // R2: one-entry mode uses only slot 0
  p_single_slot_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (wr_ptr == '0) && (rd_ptr == '0));

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_q,
  input  logic [2:0]    thr_sel,
  input  logic          push_acc,
  input  logic          pop_acc,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_nx,
  input  logic          lvl_clr,
  input  logic          tmo_clr,
  output logic          lvl_q,
  output logic          tmo_q
);
  import rxq_pkg::*;

  logic [CW-1:0] thr;
  logic          lvl_set, lvl_drop, tmo_set, tmo_drop;

  assign thr      = CW'(rx_thresh(thr_sel, mode_q, DEPTH));
  assign lvl_set  = push_acc && (cnt_q < thr) && (cnt_nx >= thr);
  assign lvl_drop = pop_acc && (cnt_nx < thr);
  assign tmo_set  = push_acc;
  assign tmo_drop = pop_acc && (cnt_nx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      lvl_q <= lvl_set | (lvl_q & ~lvl_clr & ~lvl_drop);
      tmo_q <= tmo_set | (tmo_q & ~tmo_clr & ~tmo_drop);
    end
  end

  // R6: every accepted push raises the timeout interrupt
  p_tmo_on_push_r6: assert property (@(posedge clk) disable iff (rst)
    push_acc |=> tmo_q);
  // R6: a pop that empties the buffer drops the timeout interrupt
  p_tmo_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_acc && !push_acc && (cnt_q == CW'(1))) |=> !tmo_q);
  // R5: a pop ending below threshold drops the level interrupt
  p_lvl_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_acc && (cnt_nx < thr)) |=> !lvl_q);
  // R5: level interrupt needs a push to rise
  p_lvl_needs_push_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_q) |-> $past(push_acc));

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [2:0]    thr_sel,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          overrun_clr,
  input  logic          lvl_clr,
  input  logic          tmo_clr,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overrun,
  output logic          lvl_irq,
  output logic          tmo_irq
);

  logic          mode_q, flush, push_acc, pop_acc;
  logic [CW-1:0] cnt_q, cnt_nx;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .push       (push),
    .pop        (pop),
    .overrun_clr(overrun_clr),
    .mode_q     (mode_q),
    .flush      (flush),
    .push_acc   (push_acc),
    .pop_acc    (pop_acc),
    .cnt_q      (cnt_q),
    .cnt_nx     (cnt_nx),
    .full_q     (full),
    .empty_q    (empty),
    .ovr_q      (overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .mode_q  (mode_q),
    .flush   (flush),
    .push_acc(push_acc),
    .pop_acc (pop_acc),
    .wdata   (push_data),
    .rdata   (rd_data)
  );

  rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .mode_q  (mode_q),
    .thr_sel (thr_sel),
    .push_acc(push_acc),
    .pop_acc (pop_acc),
    .cnt_q   (cnt_q),
    .cnt_nx  (cnt_nx),
    .lvl_clr (lvl_clr),
    .tmo_clr (tmo_clr),
    .lvl_q   (lvl_irq),
    .tmo_q   (tmo_irq)
  );

  assign count = cnt_q;

  // R9: output data only changes after an accepted pop
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !pop_acc |=> $stable(rd_data));
  // R3: a mode change leaves the overrun flag alone unless cleared
  p_flush_keeps_ovr_r3: assert property (@(posedge clk) disable iff (rst)
    (flush && !overrun_clr && overrun) |=> overrun);

endmodule

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0;
  logic [2:0] thr_sel = 3'd2;
  logic       push = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       pop = 1'b0;
  logic       overrun_clr = 1'b0;
  logic       lvl_clr = 1'b0;
  logic       tmo_clr = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic       full, empty, overrun, lvl_irq, tmo_irq;

  always #10 clk = ~clk;   // 50 MHz

  uart_rx_buffer uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .thr_sel(thr_sel),
    .push(push), .push_data(push_data), .pop(pop),
    .overrun_clr(overrun_clr), .lvl_clr(lvl_clr), .tmo_clr(tmo_clr),
    .rd_data(rd_data), .count(count), .full(full), .empty(empty),
    .overrun(overrun), .lvl_irq(lvl_irq), .tmo_irq(tmo_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  byte unsigned q[$];
  bit  m_en = 0, m_lvl = 0, m_tmo = 0, m_ovr = 0;
  byte unsigned m_dout = 0;

  function automatic int exp_thr(input bit en, input int sel);
    if (!en) return 1;
    case (sel)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 12;
      4: return 14;
      default: return 16;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int cap, n, n2, thr;
    bit pa, pu;
    if (rst) begin
      q.delete(); m_en = 0; m_lvl = 0; m_tmo = 0; m_ovr = 0; m_dout = 0;
      return;
    end
    if (lvl_clr) m_lvl = 0;
    if (tmo_clr) m_tmo = 0;
    if (overrun_clr) m_ovr = 0;
    if (fifo_en != m_en) begin
      q.delete();
      m_en = fifo_en;
      return;
    end
    cap = m_en ? 16 : 1;
    n   = q.size();
    thr = exp_thr(m_en, int'(thr_sel));
    pa  = pop && (n > 0);
    pu  = push && ((n < cap) || pa);
    if (pa) m_dout = q.pop_front();
    if (pu) q.push_back(push_data);
    n2 = q.size();
    if (push && !pu) m_ovr = 1;
    if (pa && n2 < thr) m_lvl = 0;
    if (pu && n < thr && n2 >= thr) m_lvl = 1;
    if (pa && n2 == 0) m_tmo = 0;
    if (pu) m_tmo = 1;
  endtask

  task automatic compare_all();
    int cap;
    cap = m_en ? 16 : 1;
    check(int'(count) == q.size(), "R2", "count", count, q.size());
    check(full == (q.size() == cap), "R2", "full", full, q.size() == cap);
    check(empty == (q.size() == 0), "R2", "empty", empty, q.size() == 0);
    check(rd_data == m_dout, "R9", "rd_data", rd_data, m_dout);
    check(lvl_irq == m_lvl, "R5", "lvl_irq", lvl_irq, m_lvl);
    check(tmo_irq == m_tmo, "R6", "tmo_irq", tmo_irq, m_tmo);
    check(overrun == m_ovr, "R7", "overrun", overrun, m_ovr);
  endtask

  // one clock: inputs already driven at the negedge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    push = 0; pop = 0; overrun_clr = 0; lvl_clr = 0; tmo_clr = 0;
  endtask

  byte unsigned seq = 8'h10;

  task automatic do_push();
    idle(); push = 1; push_data = seq; seq++; cyc(); idle();
  endtask

  task automatic do_pop();
    idle(); pop = 1; cyc(); idle();
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    byte unsigned first;
    int got;
    @(negedge clk);
    rst = 1; cyc(); cyc(); rst = 0; idle(); cyc();
    // R1: reset state
    check(count == 0 && empty && !full && rd_data == 0 && !overrun &&
          !lvl_irq && !tmo_irq, "R1", "reset state", count, 0);

    // One-entry mode: fill, overrun, pop (R2, R7, R4 threshold 1)
    first = seq;
    do_push();
    check(full && lvl_irq, "R4", "one-entry threshold 1", lvl_irq, 1);
    do_push();
    check(overrun && count == 1, "R7", "overrun on full", count, 1);
    overrun_clr = 1; push = 1; push_data = 8'hEE; cyc(); idle();
    check(overrun, "R7", "discard wins over clear", overrun, 1);
    do_pop();
    check(rd_data == first, "R7", "kept first char", rd_data, first);
    overrun_clr = 1; cyc(); idle();

    // R8: pop on empty ignored, then push+pop in one cycle
    do_pop();
    check(count == 0 && rd_data == first, "R8", "pop on empty", count, 0);
    do_push();
    pop = 1; push = 1; push_data = 8'hA5; cyc(); idle();
    check(count == 1, "R8", "push+pop keeps count", count, 1);

    // R3: switch to FIFO mode flushes; flags kept
    do_push();  // overrun while holding one
    fifo_en = 1; push = 1; pop = 1; push_data = 8'h77; cyc(); idle();
    check(count == 0 && empty && overrun && tmo_irq, "R3", "flush on enable",
          count, 0);
    overrun_clr = 1; tmo_clr = 1; lvl_clr = 1; cyc(); idle();

    // R4/R5 sweep of every threshold code
    for (int s = 0; s < 8; s++) begin
      thr_sel = 3'(s);
      lvl_clr = 1; tmo_clr = 1; cyc(); idle();
      while (q.size() > 0) do_pop();
      got = 0;
      for (int k = 1; k <= 16; k++) begin
        do_push();
        if (lvl_irq) begin got = k; break; end
      end
      check(got == exp_thr(1, s), "R4", "threshold for code", got, exp_thr(1, s));
    end

    // Now full (code 7): overrun at depth 16, push+pop at full (R2, R8)
    check(full && count == 16, "R2", "depth 16", count, 16);
    do_push();
    check(count == 16 && overrun, "R7", "overrun at 16", count, 16);
    push = 1; pop = 1; push_data = 8'h3C; cyc(); idle();
    check(count == 16, "R8", "push+pop at full", count, 16);

    // R5: select change alone does not raise; R10 clear then set-over-clear
    thr_sel = 3'd2; lvl_clr = 1; cyc(); idle();
    check(!lvl_irq, "R10", "lvl_clr clears", lvl_irq, 0);
    while (q.size() > 7) do_pop();
    check(!lvl_irq, "R5", "below threshold", lvl_irq, 0);
    lvl_clr = 1; tmo_clr = 1; push = 1; push_data = 8'h81; cyc(); idle();
    check(lvl_irq && tmo_irq, "R10", "set beats clear", lvl_irq, 1);
    thr_sel = 3'd0; cyc();
    do_pop();
    check(lvl_irq, "R5", "pop above threshold keeps", lvl_irq, 1);
    while (q.size() > 0) do_pop();
    check(!tmo_irq && !lvl_irq, "R6", "empty drops timeout", tmo_irq, 0);

    // R3: disable with data, back to one-entry
    do_push(); do_push();
    fifo_en = 0; cyc();
    check(count == 0 && tmo_irq, "R3", "flush on disable", count, 0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      push = ($urandom_range(0, 1) == 1);
      push_data = 8'($urandom_range(0, 255));
      pop  = ($urandom_range(0, 2) == 0);
      overrun_clr = ($urandom_range(0, 15) == 0);
      lvl_clr = ($urandom_range(0, 15) == 0);
      tmo_clr = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 63) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 31) == 0) thr_sel = 3'($urandom_range(0, 7));
      cyc();
    end
    idle(); cyc();
    finish_run();
  end

endmodule